// File: doc/BRIEF.md
# Set-Associative Data Cache with Selectable Write Policies

This block is a small set-associative data cache. It sits between a processor load/store port and a main-memory port that moves one word per request/acknowledge handshake. Each processor access carries a byte address. The low bits pick the byte within a word and then the word within a line. The bits above them pick the set, and the rest form the tag. The block address is the byte address divided by the line size in bytes. All sizes are parameters: one way gives a direct-mapped cache, and a way count equal to the line count gives a single fully associative set.

Two compile-time parameters choose the write behaviour, and each is chosen without regard to the other:
- `WRITE_BACK` decides what a store hit does. It either updates the cache and memory together (write-through), or it updates only the cache and marks the line dirty (write-back).
- `WRITE_ALLOC` decides what a store miss does. It either sends the word straight to memory and leaves the cache untouched, or it fills the line and merges the stored word into it.

Replacement is least-recently-used within a set. An access that needs memory raises a stall until the last memory acknowledge. A one-cycle completion pulse follows, carrying the load data.

Top module: `wpcache`

## Requirements
- R1: With the defaults (32-bit words, two words per line, four sets), address bits [1:0] are the byte, bit [2] is the word in the line, bits [4:3] are the set and bits [11:5] are the tag. Two byte addresses in the same 8-byte block share one line, so after a load of one of them, a load of the other hits.
- R2: After reset every line is invalid. `cpu_stall`, `cpu_ack` and `mem_req` are low, and the first load to any address misses and fetches its line.
- R3: A load hit keeps `cpu_stall` low, raises `cpu_ack` with the word on `cpu_rdata` in the next cycle, and makes no memory request.
- R4: With write-through, a store hit updates the cached word and issues exactly one memory write of that word. `cpu_ack` follows that write's acknowledge, and no line is ever written back on eviction.
- R5: With write-back, a store hit updates only the cached word and marks the line dirty. It completes like a load hit, with no memory traffic.
- R6: With write-back, replacing a dirty line first writes all of its words to memory, and only then issues the first fill read. Any number of stores to a line cause one write per word at eviction. Replacing a clean line writes nothing.
- R7: With write-around, a store miss issues one memory write and changes no tag, valid or data state, so a later load of that address misses and returns the stored word from memory.
- R8: With allocate-on-write, a store miss fills the line (after writing back a dirty victim) and merges the stored word. Write-through also writes that word to memory. A later load of the line hits.
- R9: On a miss, an invalid way is used first. Otherwise the least recently used way of the set is replaced, and both hits and fills count as uses.
- R10: `cpu_stall` is high in the request cycle of any access that needs memory, and stays high through the cycle of its final memory acknowledge. `cpu_ack` then pulses for one cycle, with `cpu_stall` low.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady. Each acknowledge completes one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, one cycle per access |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ack |
| cpu_ack | output | 1 | Access complete, one-cycle pulse |
| cpu_stall | output | 1 | Access is waiting on memory |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory word done |

## Verification
Four copies of the cache run side by side, one per pairing of hit policy and miss policy, and all of them receive the same access sequence. The bench aims at the sequence that evicts a line written three times. A write-back cache that forgot the dirty bit would lose the stored words. One that wrote back after the fill read would hand memory a line that was already overwritten. One that wrote on every store would show more writes to the word than expected. The bench also checks:
- that the least recently used way is the one replaced, since swapping the age order would make a later load of the kept line miss;
- that a write-around store leaves no trace in the cache, since a wrongly allocated line would turn the following load into a hit;
- that an allocating store merges its word into the filled line, since a dropped merge would return stale memory data on the later hit.

// File: rtl/wpcache.sv
module wpcache #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 2,
  parameter int SETS        = 4,
  parameter int WAYS        = 2,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int BYTE_B = $clog2(DATA_W / 8);
  localparam int WRD_B  = $clog2(LINE_WORDS);
  localparam int SET_B  = $clog2(SETS);
  localparam int BLK_SH = BYTE_B + WRD_B;
  localparam int TAG_W  = ADDR_W - BLK_SH - SET_B;
  localparam int SI_W   = (SET_B > 0) ? SET_B : 1;
  localparam int WI_W   = (WRD_B > 0) ? WRD_B : 1;
  localparam int WY_W   = ($clog2(WAYS) > 0) ? $clog2(WAYS) : 1;
  localparam int AGE_W  = $clog2(WAYS) + 1;
  localparam logic [WI_W-1:0]  LASTW  = WI_W'(LINE_WORDS - 1);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL, S_WRITE} st_t;

  function automatic logic [SI_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] s;
    s = a >> BLK_SH;
    return (SETS > 1) ? s[SI_W-1:0] : '0;
  endfunction

  function automatic logic [WI_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] s;
    s = a >> BYTE_B;
    return (LINE_WORDS > 1) ? s[WI_W-1:0] : '0;
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] s;
    s = a >> (BLK_SH + SET_B);
    return s[TAG_W-1:0];
  endfunction

  logic              vld   [SETS][WAYS];
  logic              drt   [SETS][WAYS];
  logic [TAG_W-1:0]  tag_a [SETS][WAYS];
  logic [AGE_W-1:0]  age   [SETS][WAYS];
  logic [DATA_W-1:0] dat   [SETS][WAYS][LINE_WORDS];

  st_t               st;
  logic              r_we, ack_q;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, rdata_q;
  logic [WY_W-1:0]   r_way;
  logic [WI_W-1:0]   w_cnt;

  logic [SI_W-1:0]   c_set, r_set;
  logic [WI_W-1:0]   c_word, r_word;
  logic [TAG_W-1:0]  c_tag, r_tag;
  logic              hit;
  logic [WY_W-1:0]   hway, vic;

  assign c_set  = set_of(cpu_addr);
  assign c_word = word_of(cpu_addr);
  assign c_tag  = tag_of(cpu_addr);
  assign r_set  = set_of(r_addr);
  assign r_word = word_of(r_addr);
  assign r_tag  = tag_of(r_addr);

  always_comb begin
    hit  = 1'b0;
    hway = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld[c_set][w] && tag_a[c_set][w] == c_tag) begin
        hit  = 1'b1;
        hway = WY_W'(w);
      end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    vic   = '0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !vld[c_set][w]) begin
        vic   = WY_W'(w);
        found = 1'b1;
      end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (age[c_set][w] == OLDEST) vic = WY_W'(w);
  end

  logic fill_last;
  assign fill_last = (st == S_FILL) && mem_ack && (w_cnt == LASTW);

  assign cpu_stall = (st != S_IDLE) ||
                     (cpu_req && !(hit && (!cpu_we || WRITE_BACK)));
  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      r_we    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_way   <= '0;
      w_cnt   <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w] <= 1'b0;
          drt[s][w] <= 1'b0;
        end
    end else begin
      ack_q <= 1'b0;
      case (st)
        S_IDLE: if (cpu_req) begin
          r_we    <= cpu_we;
          r_addr  <= cpu_addr;
          r_wdata <= cpu_wdata;
          w_cnt   <= '0;
          if (hit) begin
            r_way <= hway;
            if (!cpu_we) begin
              rdata_q <= dat[c_set][hway][c_word];
              ack_q   <= 1'b1;
            end else if (WRITE_BACK) begin
              drt[c_set][hway] <= 1'b1;
              ack_q            <= 1'b1;
            end else begin
              st <= S_WRITE;
            end
          end else if (!cpu_we || WRITE_ALLOC) begin
            r_way <= vic;
            st    <= (WRITE_BACK && vld[c_set][vic] && drt[c_set][vic]) ? S_EVICT : S_FILL;
          end else begin
            st <= S_WRITE;
          end
        end
        S_EVICT: if (mem_ack) begin
          if (w_cnt == LASTW) begin
            w_cnt             <= '0;
            drt[r_set][r_way] <= 1'b0;
            st                <= S_FILL;
          end else begin
            w_cnt <= w_cnt + 1'b1;
          end
        end
        S_FILL: if (mem_ack) begin
          if (!r_we && w_cnt == r_word) rdata_q <= mem_rdata;
          if (w_cnt == LASTW) begin
            vld[r_set][r_way] <= 1'b1;
            drt[r_set][r_way] <= r_we && WRITE_BACK;
            if (r_we && !WRITE_BACK) st <= S_WRITE;
            else begin
              st    <= S_IDLE;
              ack_q <= 1'b1;
            end
          end else begin
            w_cnt <= w_cnt + 1'b1;
          end
        end
        S_WRITE: if (mem_ack) begin
          st    <= S_IDLE;
          ack_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && cpu_req && hit && cpu_we)
      dat[c_set][hway][c_word] <= cpu_wdata;
    if (st == S_FILL && mem_ack) begin
      dat[r_set][r_way][w_cnt] <= (r_we && w_cnt == r_word) ? r_wdata : mem_rdata;
      if (w_cnt == LASTW) tag_a[r_set][r_way] <= r_tag;
    end
  end

  logic            t_en;
  logic [SI_W-1:0] t_set;
  logic [WY_W-1:0] t_way;
  assign t_en  = (st == S_IDLE && cpu_req && hit) || fill_last;
  assign t_set = (st == S_IDLE) ? c_set : r_set;
  assign t_way = (st == S_IDLE) ? hway : r_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= AGE_W'(w);
    end else if (t_en) begin
      for (int w = 0; w < WAYS; w++)
        if (age[t_set][w] < age[t_set][t_way])
          age[t_set][w] <= age[t_set][w] + 1'b1;
      age[t_set][t_way] <= '0;
    end
  end

  logic [ADDR_W-1:0] v_blk, r_blk, w_off;
  assign v_blk = (ADDR_W'(tag_a[r_set][r_way]) << SET_B) | ADDR_W'(r_set);
  assign r_blk = r_addr >> BLK_SH;
  assign w_off = ADDR_W'(w_cnt) << BYTE_B;

  assign mem_req = (st != S_IDLE);
  assign mem_we  = (st == S_EVICT) || (st == S_WRITE);

  always_comb begin
    case (st)
      S_EVICT: mem_addr = (v_blk << BLK_SH) | w_off;
      S_FILL:  mem_addr = (r_blk << BLK_SH) | w_off;
      S_WRITE: mem_addr = (r_addr >> BYTE_B) << BYTE_B;
      default: mem_addr = '0;
    endcase
    case (st)
      S_EVICT: mem_wdata = dat[r_set][r_way][w_cnt];
      S_WRITE: mem_wdata = r_wdata;
      default: mem_wdata = '0;
    endcase
  end

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_stall |=> cpu_ack && !mem_req); // R3
  AST_MEM_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_stall); // R10
  AST_ACK_QUIET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !mem_req); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_EVICT_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL |=> st != S_EVICT); // R6
  AST_WT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK |-> st != S_EVICT); // R4
  AST_NOALLOC_NO_STORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_ALLOC && st == S_FILL |-> !r_we); // R7
endmodule

// File: tb/wpcache_env.sv
module wpcache_env #(
  parameter bit WB = 1'b1,
  parameter bit WA = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_err
);
  localparam int ADDR_W = 12;
  localparam int MW     = 1 << (ADDR_W - 2);
  localparam int LAT    = 2;

  logic        cpu_req, cpu_we, cpu_ack, cpu_stall;
  logic [11:0] cpu_addr, mem_addr;
  logic [31:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_ack;

  wpcache #(.ADDR_W(ADDR_W), .WRITE_BACK(WB), .WRITE_ALLOC(WA)) u_wpcache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [31:0] mem     [MW];
  logic [31:0] ref_mem [MW];
  int rd_cnt, wr_cnt, wr_a_cnt, wait_c, cyc, op_rd0, first_rd, last_wr;

  localparam logic [11:0] A  = 12'h040;
  localparam logic [11:0] A4 = 12'h044;
  localparam logic [11:0] B  = 12'h060;
  localparam logic [11:0] C  = 12'h080;
  localparam logic [11:0] D  = 12'h0A8;

  initial begin
    for (int i = 0; i < MW; i++) begin
      mem[i]     = 32'h5A00_0000 ^ (i * 32'h0001_0003);
      ref_mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0003);
    end
    mem_ack = 1'b0; mem_rdata = '0;
    rd_cnt = 0; wr_cnt = 0; wr_a_cnt = 0; wait_c = 0; cyc = 0;
    first_rd = -1; last_wr = -1; op_rd0 = 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_c == LAT) begin
        wait_c  <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          wr_cnt  = wr_cnt + 1;
          last_wr = cyc;
          if (mem_addr == A) wr_a_cnt = wr_a_cnt + 1;
        end else begin
          mem_rdata <= mem[mem_addr[11:2]];
          if (rd_cnt == op_rd0) first_rd = cyc;
          rd_cnt = rd_cnt + 1;
        end
      end else begin
        wait_c <= wait_c + 1;
      end
    end
  end

  typedef struct {
    bit          ld;
    logic [31:0] d;
    string       tg;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s [wb=%0d alloc=%0d] actual=%h expected=%h", rq, WB, WA, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cpu_ack) begin
      if (sb_q.size() == 0) chk(1'b0, "R10 unexpected ack", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.ld) chk(cpu_rdata == e.d, e.tg, cpu_rdata, e.d);
      end
    end
  end

  task automatic do_op(input bit we, input logic [11:0] a, input logic [31:0] wd,
                       input int erd, input int ewr, input string rq);
    int r0, w0, n;
    bit st0;
    exp_t e;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    e.ld = !we; e.d = ref_mem[a[11:2]]; e.tg = {rq, " load data"};
    if (we) ref_mem[a[11:2]] = wd;
    sb_q.push_back(e);
    r0 = rd_cnt; w0 = wr_cnt; op_rd0 = rd_cnt; first_rd = -1; last_wr = -1;
    #1 st0 = cpu_stall;
    @(negedge clk);
    cpu_req = 1'b0;
    n = 1;
    while (!cpu_ack && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(st0 == ((erd + ewr) > 0), {rq, " R10 stall in request cycle"}, 32'(st0), 32'((erd + ewr) > 0));
    if ((erd + ewr) == 0) chk(n == 1, {rq, " R3 one-cycle completion"}, 32'(n), 32'd1);
    else chk(n > 1 && n < 500, {rq, " R10 completes after memory"}, 32'(n), 32'd2);
    chk(!cpu_stall, {rq, " R10 stall low with ack"}, 32'(cpu_stall), 32'd0);
    chk(rd_cnt - r0 == erd, {rq, " memory reads"}, 32'(rd_cnt - r0), 32'(erd));
    chk(wr_cnt - w0 == ewr, {rq, " memory writes"}, 32'(wr_cnt - w0), 32'(ewr));
    if (first_rd >= 0 && last_wr >= 0 && ewr > 1)
      chk(last_wr < first_rd, {rq, " R6 write-back precedes fill"}, 32'(last_wr), 32'(first_rd));
  endtask

  initial begin
    int wt;
    wt = WB ? 0 : 1;
    done = 1'b0; n_chk = 0; n_err = 0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    @(posedge rst_n);
    @(negedge clk);
    chk(!cpu_stall && !cpu_ack && !mem_req, "R2 idle after reset",
        {29'd0, cpu_stall, cpu_ack, mem_req}, 32'd0);
    do_op(1'b0, A,  '0, 2, 0, "R2 cold load");
    do_op(1'b0, A4, '0, 0, 0, "R1 same-line load");
    do_op(1'b1, A,  32'hC0DE_0001, 0, wt, "R4/R5 store hit");
    chk(mem[A[11:2]] == (WB ? (32'h5A00_0000 ^ (32'(A[11:2]) * 32'h0001_0003)) : 32'hC0DE_0001),
        "R4/R5 memory after store hit", mem[A[11:2]], WB ? 32'h0 : 32'hC0DE_0001);
    do_op(1'b1, A,  32'hC0DE_0002, 0, wt, "R5 repeat store hit");
    do_op(1'b1, A4, 32'hC0DE_0003, 0, wt, "R5 other word store hit");
    do_op(1'b0, A,  '0, 0, 0, "R3 load hit after store");
    do_op(1'b0, B,  '0, 2, 0, "R9 fill invalid way");
    do_op(1'b0, A,  '0, 0, 0, "R9 touch A");
    do_op(1'b0, C,  '0, 2, 0, "R9 evict clean lru B");
    do_op(1'b0, A,  '0, 0, 0, "R9 A retained");
    do_op(1'b0, B,  '0, 2, 0, "R9 B was evicted");
    do_op(1'b0, C,  '0, 2, WB ? 2 : 0, "R6 evict dirty A");
    chk(mem[A[11:2]] == 32'hC0DE_0002 && mem[A4[11:2]] == 32'hC0DE_0003,
        "R6 line contents in memory", mem[A[11:2]], 32'hC0DE_0002);
    chk(wr_a_cnt == (WB ? 1 : 2), "R6 writes to one word", 32'(wr_a_cnt), WB ? 32'd1 : 32'd2);
    do_op(1'b0, A,  '0, 2, 0, "R6 reload after eviction");
    if (!WA) begin
      do_op(1'b1, D, 32'hD00D_0004, 0, 1, "R7 store miss around");
      chk(mem[D[11:2]] == 32'hD00D_0004, "R7 memory written", mem[D[11:2]], 32'hD00D_0004);
      do_op(1'b0, D, '0, 2, 0, "R7 load still misses");
    end else begin
      do_op(1'b1, D, 32'hD00D_0004, 2, wt, "R8 store miss allocates");
      do_op(1'b0, D, '0, 0, 0, "R8 load hits merged word");
    end
    do_op(1'b1, D + 12'd4, 32'hD00D_0005, 0, wt, "R4/R5 store hit second word");
    do_op(1'b0, D + 12'd4, '0, 0, 0, "R3 load hit second word");
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R10 every access acknowledged", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
  end
endmodule

// File: tb/wpcache_bench.sv
module wpcache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic d0, d1, d2, d3;
  int c0, c1, c2, c3, e0, e1, e2, e3;

  wpcache_env #(.WB(1'b1), .WA(1'b1)) u_env_wb_alloc (.clk(clk), .rst_n(rst_n), .done(d0), .n_chk(c0), .n_err(e0));
  wpcache_env #(.WB(1'b1), .WA(1'b0)) u_env_wb_around(.clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_err(e1));
  wpcache_env #(.WB(1'b0), .WA(1'b1)) u_env_wt_alloc (.clk(clk), .rst_n(rst_n), .done(d2), .n_chk(c2), .n_err(e2));
  wpcache_env #(.WB(1'b0), .WA(1'b0)) u_env_wt_around(.clk(clk), .rst_n(rst_n), .done(d3), .n_chk(c3), .n_err(e3));

  initial begin
    int n;
    int tchk, terr;
    n = 0; tchk = 0; terr = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    while (!(d0 && d1 && d2 && d3) && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!(d0 && d1 && d2 && d3)) begin
      tchk = 1; terr = 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", n, WATCHDOG);
    end
    #1;
    $display("CHECKS %0d ERRORS %0d", c0 + c1 + c2 + c3 + tchk, e0 + e1 + e2 + e3 + terr);
    $finish;
  end
endmodule